// File: doc/BRIEF.md
# Tagged Pointer Memory Router

This block sits between an accelerator datapath and the local storage that holds its arrays. Each array lives in its own on-chip RAM, and the datapath addresses all of them through one 32-bit pointer. The upper nine bits of that pointer are a tag that names the RAM. The lower 23 bits are the element index inside that RAM. Software assigns the tags.

Tag 0 marks a null pointer. Tag 1 sends the access to off-chip memory. The block forwards it to a request/response stub port and holds off new requests until that stub answers. Tags from 2 upward name the on-chip RAMs in order. An access that is null, has no RAM behind its tag, or has an index past the end of the RAM gives an error response and leaves memory untouched.

Top module: `tagptr_mem_router`

## Requirements
- R1: The pointer's bits 31..23 are the tag and bits 22..0 are the index. For an on-chip RAM the index is used unchanged as its word address.
- R2: Tag values 2, 3, 4 and 5 each select a separate 128-word RAM. The same index under different tags holds independent data.
- R3: An accepted on-chip read raises resp_valid exactly one cycle later, with the word from the RAM its tag selected. Back-to-back reads to different RAMs each return their own RAM's data.
- R4: An accepted on-chip write raises resp_valid one cycle later with resp_err 0 and resp_rdata 0. It changes only the addressed word of the selected RAM.
- R5: An access with tag 0 responds one cycle later with resp_err 1 and resp_rdata 0. If it is a write, no RAM changes.
- R6: An access with tag 6 or higher responds one cycle later with resp_err 1 and resp_rdata 0. It changes no RAM.
- R7: An access with tag 2..5 and an index of 128 or more responds with resp_err 1 and resp_rdata 0. It does not write the aliased low word.
- R8: An access with tag 1 drives ext_req_valid in the same cycle, with ext_req_addr equal to the index and ext_req_we and ext_req_wdata copied. req_ready then stays 0 and no response appears until ext_resp_valid is 1. In that cycle resp_valid is 1, resp_rdata equals ext_resp_rdata and resp_err is 0. After that, req_ready returns to 1.
- R9: After reset, resp_valid and ext_req_valid are 0 and req_ready is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted (low while an off-chip access is outstanding) |
| req_addr | input | 32 | Tagged pointer |
| req_we | input | 1 | 1 = store, 0 = load |
| req_wdata | input | 32 | Store data |
| resp_valid | output | 1 | Response present |
| resp_rdata | output | 32 | Load data, 0 for stores and errors |
| resp_err | output | 1 | Null, unmapped or out-of-range access |
| ext_req_valid | output | 1 | Off-chip request strobe |
| ext_req_addr | output | 23 | Off-chip word index |
| ext_req_we | output | 1 | Off-chip store |
| ext_req_wdata | output | 32 | Off-chip store data |
| ext_resp_valid | input | 1 | Off-chip answer present |
| ext_resp_rdata | input | 32 | Off-chip load data |

## Verification
Alternating back-to-back reads between two RAMs catch a design that mixes by the live tag instead of the registered one. Such a design returns the next RAM's word. A write with index 128+k, followed by a read of index k, exposes a design that truncates the index and silently corrupts word k. Null and unmapped stores are followed by reads of every RAM at that index, so any stray write enable shows up. The off-chip sequence checks that no response leaks out before the stub answers and that the block stalls new requests while one is outstanding.

// File: rtl/tagptr_mem_router.sv
module tagptr_mem_router #(
  parameter int ADDR_W    = 32,
  parameter int TAG_W     = 9,
  parameter int DATA_W    = 32,
  parameter int NUM_RAMS  = 4,
  parameter int RAM_DEPTH = 128,
  parameter int FIRST_TAG = 2,
  parameter int EXT_TAG   = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_we,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              resp_valid,
  output logic [DATA_W-1:0] resp_rdata,
  output logic              resp_err,
  output logic              ext_req_valid,
  output logic [ADDR_W-TAG_W-1:0] ext_req_addr,
  output logic              ext_req_we,
  output logic [DATA_W-1:0] ext_req_wdata,
  input  logic              ext_resp_valid,
  input  logic [DATA_W-1:0] ext_resp_rdata
);
  localparam int IDX_W  = ADDR_W - TAG_W;
  localparam int WA_W   = $clog2(RAM_DEPTH);
  localparam int SEL_W  = (NUM_RAMS > 1) ? $clog2(NUM_RAMS) : 1;

  logic [TAG_W-1:0] tag;
  logic [IDX_W-1:0] idx;
  logic [TAG_W-1:0] tag_off;
  logic [SEL_W-1:0] sel;
  logic             accept, is_ext, mapped, in_range, local_ok;
  logic [NUM_RAMS-1:0] ram_en;
  logic [NUM_RAMS-1:0][DATA_W-1:0] rd_bus;

  logic             pend;
  logic             rsp_q, err_q, we_q;
  logic [SEL_W-1:0] sel_q;

  assign tag      = req_addr[ADDR_W-1:IDX_W];
  assign idx      = req_addr[IDX_W-1:0];
  assign tag_off  = tag - TAG_W'(FIRST_TAG);
  assign sel      = tag_off[SEL_W-1:0];
  assign req_ready = !pend;
  assign accept   = req_valid && req_ready;
  assign is_ext   = (tag == TAG_W'(EXT_TAG));
  assign mapped   = (tag >= TAG_W'(FIRST_TAG)) && (tag < TAG_W'(FIRST_TAG + NUM_RAMS));
  assign in_range = (idx < IDX_W'(RAM_DEPTH));
  assign local_ok = accept && !is_ext && mapped && in_range;

  assign ext_req_valid = accept && is_ext;
  assign ext_req_addr  = idx;
  assign ext_req_we    = req_we;
  assign ext_req_wdata = req_wdata;

  for (genvar g = 0; g < NUM_RAMS; g++) begin : g_ram
    logic [DATA_W-1:0] mem [RAM_DEPTH];
    logic [DATA_W-1:0] q;
    assign ram_en[g] = local_ok && (sel == SEL_W'(g));
    always_ff @(posedge clk) begin
      if (ram_en[g]) begin
        if (req_we) mem[idx[WA_W-1:0]] <= req_wdata;
        else        q <= mem[idx[WA_W-1:0]];
      end
    end
    assign rd_bus[g] = q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend  <= 1'b0;
      rsp_q <= 1'b0;
      err_q <= 1'b0;
      we_q  <= 1'b0;
      sel_q <= '0;
    end else begin
      if (ext_req_valid)       pend <= 1'b1;
      else if (ext_resp_valid) pend <= 1'b0;
      rsp_q <= accept && !is_ext;
      err_q <= !(mapped && in_range);
      we_q  <= req_we;
      sel_q <= sel;
    end
  end

  assign resp_valid = rsp_q || (pend && ext_resp_valid);
  assign resp_err   = rsp_q && err_q;
  assign resp_rdata = (pend && ext_resp_valid) ? ext_resp_rdata :
                      (rsp_q && !err_q && !we_q) ? rd_bus[sel_q] : '0;

  a_r4_one_ram_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ram_en));
  a_r5_err_returns_zero: assert property (@(posedge clk) disable iff (!rst_n)
    resp_err |-> (resp_rdata == '0));
  a_r8_ext_only_tag_one: assert property (@(posedge clk) disable iff (!rst_n)
    ext_req_valid |-> (req_addr[ADDR_W-1:IDX_W] == TAG_W'(EXT_TAG)));
  a_r8_stall_after_ext: assert property (@(posedge clk) disable iff (!rst_n)
    ext_req_valid |=> !req_ready);
  a_r8_resp_on_ext_answer: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_ready && ext_resp_valid) |-> (resp_valid && !resp_err));
  a_r3_local_resp_next: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_addr[ADDR_W-1:IDX_W] != TAG_W'(EXT_TAG)) |=> resp_valid);
  a_r8_no_ext_while_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    !req_ready |-> !ext_req_valid);
endmodule

// File: tb/tagptr_mem_router_tb_top.sv
module tagptr_mem_router_tb_top;
  logic clk = 0;
  logic rst_n = 0;
  logic req_valid = 0, req_we = 0;
  logic [31:0] req_addr = 0, req_wdata = 0;
  logic req_ready, resp_valid, resp_err;
  logic [31:0] resp_rdata;
  logic ext_req_valid, ext_req_we;
  logic [22:0] ext_req_addr;
  logic [31:0] ext_req_wdata;
  logic ext_resp_valid = 0;
  logic [31:0] ext_resp_rdata = 0;

  int n_chk = 0, n_bad = 0;
  logic rv, re;
  logic [31:0] rd;

  always #10 clk = ~clk;

  tagptr_mem_router dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_we(req_we), .req_wdata(req_wdata),
    .resp_valid(resp_valid), .resp_rdata(resp_rdata), .resp_err(resp_err),
    .ext_req_valid(ext_req_valid), .ext_req_addr(ext_req_addr),
    .ext_req_we(ext_req_we), .ext_req_wdata(ext_req_wdata),
    .ext_resp_valid(ext_resp_valid), .ext_resp_rdata(ext_resp_rdata));

  function automatic logic [31:0] ptr(input int t, input int i);
    return {t[8:0], i[22:0]};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [31:0] a, input logic w, input logic [31:0] d);
    req_valid = 1; req_addr = a; req_we = w; req_wdata = d;
    @(negedge clk);
    rv = resp_valid; re = resp_err; rd = resp_rdata;
    req_valid = 0; req_we = 0;
  endtask

  task automatic wr_ok(input int t, input int i, input logic [31:0] d, input string req);
    issue(ptr(t, i), 1, d);
    check({req, " wr valid"}, {31'd0, rv}, 1);
    check({req, " wr err"}, {31'd0, re}, 0);
    check({req, " wr data"}, rd, 0);
  endtask

  task automatic rd_exp(input int t, input int i, input logic [31:0] e, input string req);
    issue(ptr(t, i), 0, 0);
    check({req, " rd valid"}, {31'd0, rv}, 1);
    check({req, " rd err"}, {31'd0, re}, 0);
    check({req, " rd data"}, rd, e);
  endtask

  task automatic bad_access(input int t, input int i, input logic w, input string req);
    issue(ptr(t, i), w, 32'hBAD0_BAD0);
    check({req, " valid"}, {31'd0, rv}, 1);
    check({req, " err"}, {31'd0, re}, 1);
    check({req, " data"}, rd, 0);
  endtask

  task automatic t_reset;
    check("R9 resp_valid", {31'd0, resp_valid}, 0);
    check("R9 ext_req_valid", {31'd0, ext_req_valid}, 0);
    check("R9 req_ready", {31'd0, req_ready}, 1);
  endtask

  task automatic t_fill;
    for (int t = 2; t < 6; t++) begin
      wr_ok(t, 5, 32'hA000_0000 + t, "R2");
      wr_ok(t, 127, 32'hB000_0000 + t, "R1");
      wr_ok(t, 0, 32'hC000_0000 + t, "R1");
    end
    for (int t = 2; t < 6; t++) begin
      rd_exp(t, 5, 32'hA000_0000 + t, "R2");
      rd_exp(t, 127, 32'hB000_0000 + t, "R1");
      rd_exp(t, 0, 32'hC000_0000 + t, "R1");
    end
  endtask

  task automatic t_back_to_back;
    req_valid = 1; req_we = 0; req_addr = ptr(2, 5);
    @(negedge clk);
    req_addr = ptr(5, 127);
    #1 check("R3 b2b first", resp_rdata, 32'hA000_0002);
    @(negedge clk);
    req_addr = ptr(3, 0);
    #1 check("R3 b2b second", resp_rdata, 32'hB000_0005);
    @(negedge clk);
    req_valid = 0;
    #1 check("R3 b2b third", resp_rdata, 32'hC000_0003);
    check("R3 b2b valid", {31'd0, resp_valid}, 1);
    @(negedge clk);
    check("R3 idle after", {31'd0, resp_valid}, 0);
  endtask

  task automatic t_errors;
    bad_access(0, 5, 1, "R5 null store");
    bad_access(0, 5, 0, "R5 null load");
    bad_access(6, 5, 1, "R6 unmapped store");
    bad_access(511, 5, 0, "R6 unmapped load");
    bad_access(3, 128 + 5, 1, "R7 range store");
    bad_access(4, 200, 0, "R7 range load");
    for (int t = 2; t < 6; t++) rd_exp(t, 5, 32'hA000_0000 + t, "R7 R5 R6 untouched");
    wr_ok(4, 5, 32'h1234_5678, "R4");
    rd_exp(4, 5, 32'h1234_5678, "R4");
    rd_exp(3, 5, 32'hA000_0003, "R4 other ram");
    rd_exp(4, 127, 32'hB000_0004, "R4 other word");
  endtask

  task automatic t_ext(input logic w, input logic [31:0] ans);
    req_valid = 1; req_addr = ptr(1, 23'h5A5A5); req_we = w; req_wdata = 32'hFEED_0001;
    #1;
    check("R8 ext strobe", {31'd0, ext_req_valid}, 1);
    check("R8 ext addr", {9'd0, ext_req_addr}, 32'h0005_A5A5);
    check("R8 ext we", {31'd0, ext_req_we}, {31'd0, w});
    check("R8 ext wdata", ext_req_wdata, 32'hFEED_0001);
    @(negedge clk);
    req_valid = 0;
    for (int k = 0; k < 3; k++) begin
      check("R8 stalled", {31'd0, req_ready}, 0);
      check("R8 no early resp", {31'd0, resp_valid}, 0);
      @(negedge clk);
    end
    ext_resp_valid = 1; ext_resp_rdata = ans;
    #1;
    check("R8 resp valid", {31'd0, resp_valid}, 1);
    check("R8 resp data", resp_rdata, ans);
    check("R8 resp err", {31'd0, resp_err}, 0);
    @(negedge clk);
    ext_resp_valid = 0;
    check("R8 ready again", {31'd0, req_ready}, 1);
    check("R8 resp over", {31'd0, resp_valid}, 0);
  endtask

  initial begin
    #1000000;
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    t_reset;
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_fill;
    t_back_to_back;
    t_errors;
    t_ext(0, 32'h0BAD_CAFE);
    t_ext(1, 32'h0000_0000);
    rd_exp(2, 5, 32'hA000_0002, "R8 local after ext");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule